// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. The caller presents the address, a two-bit access mode (0 is kernel), a three-bit set of wanted rights and the table base, and pulses `start`. The block first screens the address: a non-canonical address is refused, and a negative address whose bits 42:41 read `10` is a kernel direct-mapped window that is translated by bit relocation alone, with no memory traffic.

Any other address is resolved by reading one 64-bit entry from each of three table levels through a simple request/valid memory port. Intermediate entries are checked for presence and kernel readability. The leaf entry supplies the page frame and the per-mode read and write enables, which are then trimmed by the entry's fault-on-operation bits. The result is returned with a one-cycle `done` pulse: a physical address and granted rights on success, or a three-bit fault code.

Top module: `pt_walker`

## Requirements
- R1: An address whose bits 63 down to the implemented width (43 by default) are not all equal is answered with fault code 1 (access violation) and no memory read.
- R2: In kernel mode (mode 0), an address with bit 63 set and bits 42:41 equal to `10` returns code 7, rights 7, and a physical address holding address bits 39:0 in place, address bit 40 at bit 43 and zeros elsewhere, without any memory read.
- R3: The same window in any mode other than 0 returns code 1 without any memory read.
- R4: Entry addresses are base plus 8 times a 10-bit index; the indices are address bits [PB+29:PB+20], [PB+19:PB+10] and [PB+9:PB] (PB is the page shift, default 13); the first base is the table base input and every later base is entry bits 63:32 shifted left by PB.
- R5: At the first two levels, entry bit 0 clear gives code 0 (not valid) and, failing that, bit 8 clear gives code 1; at the third level only bit 0 clear faults (code 0).
- R6: Rights are encoded bit 0 read, bit 1 write, bit 2 execute. At the leaf, read and execute are granted by entry bit 8+mode and write by entry bit 12+mode; a nonzero wanted set disjoint from the granted set gives code 1.
- R7: Leaf bits 1, 2 and 3 withdraw read, write and execute respectively; if a nonzero wanted set then has nothing left, the code is 3 when execute was wanted, else 4 when write was wanted, else 2.
- R8: A request with an empty wanted set never gets code 2, 3 or 4; a valid leaf answers it with code 7 and the trimmed rights.
- R9: A successful walk returns code 7, the trimmed rights, and the leaf frame address ORed with address bits PB-1:0.
- R10: Every fault returns a physical address of 0 and rights 0.
- R11: `done` lasts one cycle; a raised `mem_req` keeps `mem_addr` steady until `mem_rvalid`; `start` while a walk is under way has no effect on its result.
- R12: After reset `done`, `mem_req`, `fault`, `pa` and `prot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a translation (taken when idle) |
| va | input | 64 | Virtual address |
| mode | input | 2 | Access mode, 0 is kernel |
| need | input | 3 | Wanted rights: bit 0 read, bit 1 write, bit 2 execute |
| ptbr | input | 64 | First-level table base |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 64 | Entry read address |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 64 | Entry read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | 0 not valid, 1 access violation, 2 fault-on-read, 3 fault-on-execute, 4 fault-on-write, 7 success |
| pa | output | 64 | Physical address |
| prot | output | 3 | Granted rights |

## Verification
The bench aims at the window relocation, where a design that kept bit 40 in place or forgot the mode check would map kernel space to the wrong frame or open it to user code, and at the address screen, where a missed bit would issue reads for illegal addresses. It drives leaf entries whose permission bits sit at the wrong mode offset and entries whose fault-on-operation bits overlap, so a reversed fault priority or a probe that faults with an empty wanted set shows up as a wrong code. It also checks that the third level ignores the kernel-read bit as a fault source, and pulses `start` during walks to catch a walker that restarts mid-flight.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int unsigned LEVELS   = 3;
    localparam int unsigned IDX_BITS = 10;
    localparam int unsigned ENT_SH   = 3;
    localparam int unsigned MODE_W   = 2;
    localparam int unsigned MODES    = 1 << MODE_W;
    localparam int unsigned ACC_W    = 3;

    localparam int unsigned ACC_RD = 0;
    localparam int unsigned ACC_WR = 1;
    localparam int unsigned ACC_EX = 2;

    localparam int unsigned WIN_SEL_LO = 41;
    localparam int unsigned WIN_KEEP   = 40;
    localparam int unsigned WIN_MOVE   = 43;

    typedef enum logic [2:0] {
        FLT_TNV  = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_FOR  = 3'd2,
        FLT_FOE  = 3'd3,
        FLT_FOW  = 3'd4,
        FLT_NONE = 3'd7
    } fault_e;

    typedef enum logic {
        ST_IDLE,
        ST_WALK
    } walk_state_e;

    typedef struct packed {
        logic [3:0] flags;
        logic [MODES-1:0] rd_en;
        logic [MODES-1:0] wr_en;
    } pte_bits_t;

    function automatic logic [63:0] entry_addr(input logic [63:0] base,
                                               input logic [63:0] vaddr,
                                               input int unsigned lvl,
                                               input int unsigned pb);
        logic [63:0] sh;
        sh = vaddr >> (pb + IDX_BITS * (LEVELS - 1 - lvl));
        return base + {{(64 - IDX_BITS - ENT_SH){1'b0}}, sh[IDX_BITS-1:0], {ENT_SH{1'b0}}};
    endfunction

    function automatic logic [63:0] frame_base(input logic [31:0] frame,
                                               input int unsigned pb);
        logic [63:0] f;
        f = {32'b0, frame};
        return f << pb;
    endfunction

endpackage

// File: rtl/va_screen.sv
module va_screen
    import pt_walk_pkg::*;
#(
    parameter int unsigned IMPL_BITS = 43
) (
    input  logic [63:0]       va,
    input  logic [MODE_W-1:0] mode,
    output logic              early,
    output fault_e            fault,
    output logic [63:0]       pa,
    output logic [ACC_W-1:0]  prot
);
    localparam int unsigned HI_W = 64 - IMPL_BITS;

    logic [HI_W-1:0] hi;
    logic            canon;
    logic            in_win;

    assign hi     = va[63:IMPL_BITS];
    assign canon  = (&hi) | ~(|hi);
    assign in_win = va[63] && (va[WIN_SEL_LO+1:WIN_SEL_LO] == 2'b10);

    always_comb begin
        early = 1'b0;
        fault = FLT_ACV;
        pa    = '0;
        prot  = '0;
        if (!canon) begin
            early = 1'b1;
        end else if (in_win) begin
            early = 1'b1;
            if (mode == '0) begin
                fault            = FLT_NONE;
                pa[WIN_KEEP-1:0] = va[WIN_KEEP-1:0];
                pa[WIN_MOVE]     = va[WIN_KEEP];
                prot             = '1;
            end
        end
    end

endmodule

// File: rtl/pte_eval.sv
module pte_eval
    import pt_walk_pkg::*;
(
    input  pte_bits_t         pte,
    input  logic              leaf,
    input  logic [MODE_W-1:0] mode,
    input  logic [ACC_W-1:0]  need,
    output logic              ok,
    output fault_e            fault,
    output logic [ACC_W-1:0]  prot
);
    logic [ACC_W-1:0] granted;
    logic [ACC_W-1:0] remain;
    logic             want_any;

    always_comb begin
        granted         = '0;
        granted[ACC_RD] = pte.rd_en[mode];
        granted[ACC_EX] = pte.rd_en[mode];
        granted[ACC_WR] = pte.wr_en[mode];
    end

    assign remain   = granted & ~pte.flags[3:1];
    assign want_any = |need;

    always_comb begin
        ok    = 1'b1;
        fault = FLT_NONE;
        prot  = '0;
        if (!pte.flags[0]) begin
            ok    = 1'b0;
            fault = FLT_TNV;
        end else if (!leaf) begin
            if (!pte.rd_en[0]) begin
                ok    = 1'b0;
                fault = FLT_ACV;
            end
        end else if (want_any && ((granted & need) == '0)) begin
            ok    = 1'b0;
            fault = FLT_ACV;
        end else if (want_any && ((remain & need) == '0)) begin
            ok = 1'b0;
            if (need[ACC_EX])      fault = FLT_FOE;
            else if (need[ACC_WR]) fault = FLT_FOW;
            else                   fault = FLT_FOR;
        end else begin
            prot = remain;
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 13,
    parameter int unsigned IMPL_BITS = 43
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] va,
    input  logic [1:0]  mode,
    input  logic [2:0]  need,
    input  logic [63:0] ptbr,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [63:0] mem_rdata,
    output logic        done,
    output logic [2:0]  fault,
    output logic [63:0] pa,
    output logic [2:0]  prot
);
    localparam int unsigned LVL_W = $clog2(LEVELS);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e       state;
    logic [LVL_W-1:0]  level;
    logic [63:0]       va_q;
    logic [MODE_W-1:0] mode_q;
    logic [ACC_W-1:0]  need_q;

    logic              scr_early;
    fault_e            scr_fault;
    logic [63:0]       scr_pa;
    logic [ACC_W-1:0]  scr_prot;

    pte_bits_t         ent;
    logic              ev_ok;
    fault_e            ev_fault;
    logic [ACC_W-1:0]  ev_prot;
    logic [63:0]       nxt_base;
    logic [63:0]       page_off;
    logic              unused_rdata;

    assign ent.flags = mem_rdata[3:0];
    assign ent.rd_en = mem_rdata[8 +: MODES];
    assign ent.wr_en = mem_rdata[12 +: MODES];
    assign nxt_base  = frame_base(mem_rdata[63:32], PAGE_BITS);
    assign page_off  = {{(64 - PAGE_BITS){1'b0}}, va_q[PAGE_BITS-1:0]};
    assign unused_rdata = ^{mem_rdata[31:16], mem_rdata[7:4]};

    va_screen #(.IMPL_BITS(IMPL_BITS)) u_screen (
        .va    (va),
        .mode  (mode),
        .early (scr_early),
        .fault (scr_fault),
        .pa    (scr_pa),
        .prot  (scr_prot)
    );

    pte_eval u_eval (
        .pte   (ent),
        .leaf  (level == LAST_LVL),
        .mode  (mode_q),
        .need  (need_q),
        .ok    (ev_ok),
        .fault (ev_fault),
        .prot  (ev_prot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            level    <= '0;
            va_q     <= '0;
            mode_q   <= '0;
            need_q   <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            fault    <= 3'd0;
            pa       <= '0;
            prot     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        va_q   <= va;
                        mode_q <= mode;
                        need_q <= need;
                        if (scr_early) begin
                            done  <= 1'b1;
                            fault <= scr_fault;
                            pa    <= scr_pa;
                            prot  <= scr_prot;
                        end else begin
                            state    <= ST_WALK;
                            level    <= '0;
                            mem_req  <= 1'b1;
                            mem_addr <= entry_addr(ptbr, va, 0, PAGE_BITS);
                        end
                    end
                end
                ST_WALK: begin
                    if (mem_rvalid) begin
                        if (!ev_ok || level == LAST_LVL) begin
                            state   <= ST_IDLE;
                            mem_req <= 1'b0;
                            done    <= 1'b1;
                            fault   <= ev_fault;
                            if (ev_ok) begin
                                pa   <= nxt_base | page_off;
                                prot <= ev_prot;
                            end else begin
                                pa   <= '0;
                                prot <= '0;
                            end
                        end else begin
                            level    <= level + 1'b1;
                            mem_addr <= entry_addr(nxt_base, va_q, int'(level) + 1, PAGE_BITS);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_rvalid,
    input logic        done,
    input logic [2:0]  fault,
    input logic [63:0] pa,
    input logic [2:0]  prot
);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    assert_no_req_at_done_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    assert_fault_zeroes_R10: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 3'd7) |-> (pa == 64'd0 && prot == 3'd0));

    assert_fault_legal_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (fault <= 3'd4 || fault == 3'd7));

endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .done       (done),
    .fault      (fault),
    .pa         (pa),
    .prot       (prot)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    localparam int PB = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] va = '0;
    logic [1:0]  mode = '0;
    logic [2:0]  need = '0;
    logic [63:0] ptbr = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [2:0]  fault;
    logic [63:0] pa;
    logic [2:0]  prot;

    int n_vec = 0;
    int n_bad = 0;
    int n_reads = 0;
    logic [63:0] rd_addr [3];
    bit finished = 0;

    logic [63:0] pmem [logic [63:0]];

    always #2.5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst(rst), .start(start), .va(va), .mode(mode), .need(need),
        .ptbr(ptbr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .pa(pa), .prot(prot)
    );

    function automatic logic [63:0] mrd(input logic [63:0] a);
        if (pmem.exists(a)) return pmem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] idx_addr(input logic [63:0] base, input logic [63:0] v, input int lvl);
        logic [63:0] s;
        s = v >> (PB + 10 * (2 - lvl));
        return base + ({54'd0, s[9:0]} << 3);
    endfunction

    function automatic logic [63:0] fbase(input logic [63:0] pte);
        return {32'd0, pte[63:32]} << PB;
    endfunction

    // memory responder: random latency, one-cycle strobe
    always begin
        @(negedge clk);
        if (mem_req && !rst) begin
            repeat ($urandom_range(0, 3)) @(negedge clk);
            mem_rvalid = 1'b1;
            mem_rdata  = mrd(mem_addr);
            @(negedge clk);
            mem_rvalid = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_rvalid) begin
            if (n_reads < 3) rd_addr[n_reads] = mem_addr;
            n_reads = n_reads + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [63:0] v, input logic [63:0] base,
                         input logic [63:0] e1, input logic [63:0] e2, input logic [63:0] e3);
        pmem[idx_addr(base, v, 0)] = e1;
        pmem[idx_addr(fbase(e1), v, 1)] = e2;
        pmem[idx_addr(fbase(e2), v, 2)] = e3;
    endtask

    task automatic ref_walk(input logic [63:0] v, input logic [1:0] m, input logic [2:0] nd,
                            input logic [63:0] base,
                            output logic [2:0] f, output logic [63:0] p, output logic [2:0] pr,
                            output int nr, output logic [63:0] ea [3]);
        logic [63:0] b, e, a;
        logic [2:0] g, rem;
        f = 3'd1; p = '0; pr = '0; nr = 0;
        for (int i = 0; i < 3; i++) ea[i] = '0;
        if (!(v[63:43] == '0 || v[63:43] == '1)) return;
        if (v[63] && v[42:41] == 2'b10) begin
            if (m != 2'd0) return;
            f = 3'd7; pr = 3'd7;
            p = {20'd0, v[40], 3'd0, v[39:0]};
            return;
        end
        b = base;
        for (int l = 0; l < 3; l++) begin
            a = idx_addr(b, v, l);
            ea[l] = a;
            nr++;
            e = mrd(a);
            if (!e[0]) begin f = 3'd0; return; end
            if (l < 2 && !e[8]) begin f = 3'd1; return; end
            b = fbase(e);
        end
        g = {e[8 + m], e[12 + m], e[8 + m]};
        if (nd != 0 && (g & nd) == 0) begin f = 3'd1; return; end
        rem = g & ~e[3:1];
        if (nd != 0 && (rem & nd) == 0) begin
            f = nd[2] ? 3'd3 : (nd[1] ? 3'd4 : 3'd2);
            return;
        end
        f = 3'd7; pr = rem; p = b | {51'd0, v[12:0]};
    endtask

    task automatic run(input string req, input logic [63:0] v, input logic [1:0] m,
                       input logic [2:0] nd, input logic [63:0] base, input bit poke,
                       output logic [2:0] f_o);
        logic [2:0] ef, epr;
        logic [63:0] epa;
        logic [63:0] ea [3];
        int enr;
        bit seen, poked;
        ref_walk(v, m, nd, base, ef, epa, epr, enr, ea);
        @(negedge clk);
        n_reads = 0;
        va = v; mode = m; need = nd; ptbr = base; start = 1'b1;
        seen = 0; poked = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin seen = 1; break; end
            if (poke && !poked && mem_req) begin
                start = 1'b1; va = ~v; mode = ~m; need = ~nd; poked = 1;
            end
        end
        f_o = fault;
        if (!seen) begin
            n_vec++; n_bad++;
            $display("FAIL %s watchdog: actual=no done expected=done", req);
            return;
        end
        check({req, " fault"}, {61'd0, fault}, {61'd0, ef});
        check({req, " pa"}, pa, epa);
        check({req, " prot"}, {61'd0, prot}, {61'd0, epr});
        check({req, " R4 reads"}, 64'(n_reads), 64'(enr));
        for (int i = 0; i < enr && i < 3; i++)
            check({req, " R4 entry addr"}, rd_addr[i], ea[i]);
        @(negedge clk);
        check({req, " R11 done width"}, {63'd0, done}, 64'd0);
    endtask

    localparam logic [63:0] V_ = 64'h1, FR = 64'h2, FW = 64'h4, FX = 64'h8;
    function automatic logic [63:0] KR(input int m); return 64'h100 << m; endfunction
    function automatic logic [63:0] KW(input int m); return 64'h1000 << m; endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] f;
        logic [63:0] v, b, e1, e2, e3, tv;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 done", {63'd0, done}, 0);
        check("R12 mem_req", {63'd0, mem_req}, 0);
        check("R12 fault", {61'd0, fault}, 0);
        check("R12 pa", pa, 0);
        check("R12 prot", {61'd0, prot}, 0);
        rst = 1'b0;

        // R1: non-canonical
        run("R1 noncanon-pos", 64'h0000_0800_0000_0000, 2'd0, 3'd1, 64'h8000, 0, f);
        check("R1 code", {61'd0, f}, 1);
        run("R1 noncanon-neg", 64'hFFFF_F000_0000_0000, 2'd0, 3'd1, 64'h8000, 0, f);
        check("R1 code", {61'd0, f}, 1);

        // R2 / R3: kernel window
        run("R2 window", 64'hFFFF_FD12_3456_789A, 2'd0, 3'd2, 64'h8000, 0, f);
        check("R2 pa exact", pa, 64'h0000_0812_3456_789A);
        run("R3 window user", 64'hFFFF_FD12_3456_789A, 2'd1, 3'd1, 64'h8000, 0, f);
        check("R3 code", {61'd0, f}, 1);

        b = 64'h4_0000;
        v = 64'h0000_0012_3456_6ABC;
        e1 = {32'h40, 32'h0} | V_ | KR(0);
        e2 = {32'h51, 32'h0} | V_ | KR(0);
        // R5: L1 invalid
        build(v, b, 64'h0, e2, 0);
        run("R5 l1 invalid", v, 2'd0, 3'd1, b, 0, f);
        check("R5 code", {61'd0, f}, 0);
        // R5: L2 without kernel read
        build(v, b, e1, {32'h51, 32'h0} | V_, 0);
        run("R5 l2 no kre", v, 2'd0, 3'd1, b, 0, f);
        check("R5 code", {61'd0, f}, 1);
        // R5/R8: leaf without kernel read does not fault on probe
        e3 = {32'h777, 32'h0} | V_ | KW(0);
        build(v, b, e1, e2, e3);
        run("R5 leaf no kre", v, 2'd0, 3'd0, b, 0, f);
        check("R5 code", {61'd0, f}, 7);
        check("R9 leaf pa", pa, (64'h777 << 13) | 64'h0ABC);
        // R6: per-mode enables
        e3 = {32'h123, 32'h0} | V_ | KR(2) | KW(1);
        build(v, b, e1, e2, e3);
        run("R6 mode2 write", v, 2'd2, 3'd2, b, 0, f);
        check("R6 code", {61'd0, f}, 1);
        run("R6 mode2 read", v, 2'd2, 3'd1, b, 0, f);
        check("R6 prot", {61'd0, prot}, 5);
        // R7: priority
        e3 = {32'h123, 32'h0} | V_ | KR(0) | KW(0) | FR | FW | FX;
        build(v, b, e1, e2, e3);
        run("R7 all", v, 2'd0, 3'd7, b, 0, f);
        check("R7 code exec", {61'd0, f}, 3);
        run("R7 rw", v, 2'd0, 3'd3, b, 0, f);
        check("R7 code write", {61'd0, f}, 4);
        run("R7 r", v, 2'd0, 3'd1, b, 0, f);
        check("R7 code read", {61'd0, f}, 2);
        // R8: probe with everything withdrawn
        run("R8 probe", v, 2'd0, 3'd0, b, 0, f);
        check("R8 code", {61'd0, f}, 7);
        check("R8 prot", {61'd0, prot}, 0);
        // R7: partial withdrawal
        e3 = {32'h123, 32'h0} | V_ | KR(0) | KW(0) | FR;
        build(v, b, e1, e2, e3);
        run("R7 exec left", v, 2'd0, 3'd4, b, 1, f);
        check("R7 prot", {61'd0, prot}, 6);

        // random mix, with start pokes during walks (R11)
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [1:0] m;
            logic [2:0] nd;
            kind = $urandom_range(0, 19);
            tv = {$urandom, $urandom};
            if (kind < 2) begin
                tv[63:43] = tv[42] ? '1 : '0;
                tv[43 + $urandom_range(0, 19)] ^= 1'b1;
            end else if (kind < 5) begin
                tv[63:43] = '1; tv[42:41] = 2'b10;
            end else begin
                tv[63:43] = tv[42] ? '1 : '0;
            end
            m  = 2'($urandom_range(0, 3));
            nd = 3'($urandom_range(0, 7));
            b  = {44'd0, 20'($urandom)} << PB;
            e1 = {12'd0, 20'($urandom), 32'($urandom)};
            e2 = {12'd0, 20'($urandom), 32'($urandom)};
            e3 = {12'd0, 20'($urandom), 32'($urandom)};
            if ($urandom_range(0, 7) != 0) e1 |= V_ | KR(0);
            if ($urandom_range(0, 7) != 0) e2 |= V_ | KR(0);
            if ($urandom_range(0, 7) != 0) e3 |= V_;
            build(tv, b, e1, e2, e3);
            run("R9 random", tv, m, nd, b, ($urandom_range(0, 1) == 1), f);
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule